// File: doc/BRIEF.md
# Dual Down-Counter Timer Unit

This block holds two independent countdown timers and a shared interrupt section, all reached through a 32-bit register port. Each timer has a reload value (divisor), a current count and a control word. The control word carries a two-bit operation code and a three-bit count-source code. The operation code loads the divisor into the counter, freezes the counter, or lets it count. Count sources are not separate clocks. Each one is a tick-enable input sampled in the block's single clock domain, and a running timer steps only on cycles where its selected tick is high.

A running timer counts down to its terminal count, reloads from its divisor and keeps going. Each terminal count sets that timer's raw interrupt bit. The raw bits are cleared by write-one-to-clear through an acknowledge register and are gated by a mask. A single interrupt line is high while any raw bit survives the mask. A free-running time counter advances on its own tick input.

Register writes take effect at the clock edge that samples the request. Reads return their data one cycle later on a registered response bus.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every readable register returns zero, both timers are stopped with operation code 0, and `irq_o` is low.
- R2: A control write with operation code 0 (bits [1:0]) copies the divisor into the counter, and the counter then stays at that value.
- R3: A control write with operation code 3 is ignored entirely: the control readback and the count are unchanged by it.
- R4: Operation code 1 freezes the counter whatever the tick inputs do.
- R5: With operation code 2, the counter drops by one on each cycle where the tick it selects is high. Source code `c` (control bits [4:2]) selects `tick_en[c-4]` for codes 4 to 7. Codes 0 to 3 never tick.
- R6: When a running timer's tick arrives while its count is 0 or 1, the count reloads from the divisor and raw bit `i` is set, where bit 0 belongs to timer 0 and bit 1 to timer 1. A divisor of `d` ≥ 1 therefore fires once every `d` ticks.
- R7: A write to offset 0x4C clears each raw bit written as one. A terminal count in the same cycle wins for its own bit. Offset 0x4C reads zero.
- R8: The mask (offset 0x48, bits [1:0]) reads back. Masked status (0x54) is raw AND mask. `irq_o` is high exactly when masked status is nonzero, from the cycle after any write that changes raw status or mask.
- R9: The time register (0x38) increments by one, wrapping, on each cycle where `time_tick` is high.
- R10: A request is accepted only with all byte enables set and `req_addr[1:0]` zero. An unaccepted write changes nothing, and an unaccepted read returns zero.
- R11: Reads of offsets outside the register map return zero, and writes to them change nothing.
- R12: The map places timer `i` at base `0x10*i`, with divisor at +0x0, count at +0x4 and control at +0x8. Control reads back as `{src, op}` in bits [4:0]. Raw status is at 0x50. A read's data appears on `rsp_data` in the cycle after the request and reflects the state before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | NUM_SRC (4) | Per-source tick enables, source code 4+k uses bit k |
| time_tick | input | 1 | Advance enable for the time counter |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (8) | Byte offset of the register |
| req_be | input | CNT_W/8 (4) | Byte enables, all must be set |
| req_wdata | input | CNT_W (32) | Write data |
| rsp_data | output | CNT_W (32) | Read data, one cycle after the request |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its default parameters: two 32-bit timers, four tick sources and an 8-bit offset. It writes small divisors at run time so that reloads and terminal counts happen within tens of cycles. Random tick patterns, random source codes (including the non-ticking ones) and random operation codes (including the illegal one) reach the collisions between control writes, acknowledges and terminal counts. A behavioural model in the bench tracks every register and predicts each read and the interrupt line on every cycle.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

    localparam int SRC_W     = 3;
    localparam int SRC_BASE  = 4;

    localparam int OFF_DIV   = 'h0;
    localparam int OFF_CNT   = 'h4;
    localparam int OFF_CTRL  = 'h8;
    localparam int CH_STRIDE = 'h10;

    localparam int ADR_TIME  = 'h38;
    localparam int ADR_MASK  = 'h48;
    localparam int ADR_ACK   = 'h4C;
    localparam int ADR_RAW   = 'h50;
    localparam int ADR_MSTAT = 'h54;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_RUN  = 2'd2,
        OP_BAD  = 2'd3
    } tmr_op_e;

endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pair_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_SRC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 div_wr,
    input  logic                 ctrl_wr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [NUM_SRC-1:0]   tick_vec,
    output logic [CNT_W-1:0]     div_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [1:0]           op_o,
    output logic [SRC_W-1:0]     src_o,
    output logic                 fire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] div;
        tmr_op_e          op;
        logic [SRC_W-1:0] src;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     tick_sel;
    logic     fire_d;
    tmr_op_e  wr_op;

    assign wr_op = tmr_op_e'(wr_data[1:0]);

    always_comb begin
        tick_sel = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (st_q.src == SRC_W'(SRC_BASE + k)) begin
                tick_sel = tick_vec[k];
            end
        end

        st_d   = st_q;
        fire_d = 1'b0;

        if (ctrl_wr && (wr_op != OP_BAD)) begin
            st_d.op  = wr_op;
            st_d.src = wr_data[SRC_W+1:2];
            if (wr_op == OP_LOAD) begin
                st_d.cnt = st_q.div;
            end
        end else if ((st_q.op == OP_RUN) && tick_sel) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.cnt = st_q.div;
                fire_d   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (div_wr) begin
            st_d.div = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, div: '0, op: OP_LOAD, src: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o  = st_q.div;
    assign cnt_o  = st_q.cnt;
    assign op_o   = st_q.op;
    assign src_o  = st_q.src;
    assign fire_o = fire_d;

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int NUM_TMR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] fire,
    input  logic               ack_wr,
    input  logic               mask_wr,
    input  logic [NUM_TMR-1:0] wr_bits,
    output logic [NUM_TMR-1:0] raw_o,
    output logic [NUM_TMR-1:0] mask_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_TMR-1:0] raw;
        logic [NUM_TMR-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic [NUM_TMR-1:0] clr_bits;

    always_comb begin
        clr_bits = ack_wr ? wr_bits : '0;
        st_d     = st_q;
        // a terminal count in the same cycle outranks the acknowledge
        st_d.raw = (st_q.raw & ~clr_bits) | fire;
        if (mask_wr) begin
            st_d.mask = wr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.raw & st_q.mask);

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pair_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 32,
    parameter int NUM_TMR = 2,
    parameter int NUM_SRC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   tick_en,
    input  logic                 time_tick,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CNT_W/8-1:0]   req_be,
    input  logic [CNT_W-1:0]     req_wdata,
    output logic [CNT_W-1:0]     rsp_data,
    output logic                 irq_o
);

    localparam int BE_W = CNT_W / 8;

    typedef struct packed {
        logic [CNT_W-1:0] tval;
        logic [CNT_W-1:0] rsp;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                 acc, wr_acc, rd_acc;
    logic [NUM_TMR-1:0]   div_wr, ctrl_wr, chan_fire;
    logic [CNT_W-1:0]     chan_div [NUM_TMR];
    logic [CNT_W-1:0]     chan_cnt [NUM_TMR];
    logic [1:0]           chan_op  [NUM_TMR];
    logic [SRC_W-1:0]     chan_src [NUM_TMR];
    logic                 ack_wr, mask_wr;
    logic [NUM_TMR-1:0]   irq_raw, irq_mask;
    logic [CNT_W-1:0]     rd_val;

    assign acc    = req_valid && (req_be == {BE_W{1'b1}}) && (req_addr[1:0] == 2'b00);
    assign wr_acc = acc && req_write;
    assign rd_acc = acc && !req_write;

    assign ack_wr  = wr_acc && (req_addr == ADDR_W'(ADR_ACK));
    assign mask_wr = wr_acc && (req_addr == ADDR_W'(ADR_MASK));

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
        assign div_wr[g]  = wr_acc && (req_addr == ADDR_W'(g * CH_STRIDE + OFF_DIV));
        assign ctrl_wr[g] = wr_acc && (req_addr == ADDR_W'(g * CH_STRIDE + OFF_CTRL));

        tmr_chan #(
            .CNT_W   (CNT_W),
            .NUM_SRC (NUM_SRC)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_wr   (div_wr[g]),
            .ctrl_wr  (ctrl_wr[g]),
            .wr_data  (req_wdata),
            .tick_vec (tick_en),
            .div_o    (chan_div[g]),
            .cnt_o    (chan_cnt[g]),
            .op_o     (chan_op[g]),
            .src_o    (chan_src[g]),
            .fire_o   (chan_fire[g])
        );
    end

    tmr_irq #(
        .NUM_TMR (NUM_TMR)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (chan_fire),
        .ack_wr  (ack_wr),
        .mask_wr (mask_wr),
        .wr_bits (req_wdata[NUM_TMR-1:0]),
        .raw_o   (irq_raw),
        .mask_o  (irq_mask),
        .irq_o   (irq_o)
    );

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (req_addr == ADDR_W'(i * CH_STRIDE + OFF_DIV)) begin
                rd_val = chan_div[i];
            end
            if (req_addr == ADDR_W'(i * CH_STRIDE + OFF_CNT)) begin
                rd_val = chan_cnt[i];
            end
            if (req_addr == ADDR_W'(i * CH_STRIDE + OFF_CTRL)) begin
                rd_val = CNT_W'({chan_src[i], chan_op[i]});
            end
        end
        if (req_addr == ADDR_W'(ADR_TIME)) begin
            rd_val = st_q.tval;
        end
        if (req_addr == ADDR_W'(ADR_MASK)) begin
            rd_val = CNT_W'(irq_mask);
        end
        if (req_addr == ADDR_W'(ADR_RAW)) begin
            rd_val = CNT_W'(irq_raw);
        end
        if (req_addr == ADDR_W'(ADR_MSTAT)) begin
            rd_val = CNT_W'(irq_raw & irq_mask);
        end
    end

    always_comb begin
        st_d = st_q;
        if (time_tick) begin
            st_d.tval = st_q.tval + CNT_W'(1);
        end
        if (rd_acc) begin
            st_d.rsp = rd_val;
        end else if (req_valid && !req_write) begin
            st_d.rsp = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_data = st_q.rsp;

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
    parameter int CNT_W   = 32,
    parameter int NUM_TMR = 2,
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_o,
    input logic [NUM_TMR-1:0] raw_q,
    input logic [NUM_TMR-1:0] mask_q,
    input logic [NUM_TMR-1:0] fire,
    input logic [1:0]         op0,
    input logic [CNT_W-1:0]   cnt0,
    input logic [4:0]         ctrl0,
    input logic               ctrl_wr0,
    input logic               ack_wr,
    input logic [1:0]         wdata_lo,
    input logic [NUM_SRC-1:0] tick_en
);

    // R3: an illegal operation code leaves the control word alone
    p_illegal_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr0 && wdata_lo == 2'b11) |=> $stable(ctrl0));

    // R4: a held counter does not move
    p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op0 == 2'd1 && !ctrl_wr0) |=> $stable(cnt0));

    // R5: with no tick at all, a running counter stays put
    p_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op0 == 2'd2 && tick_en == '0 && !ctrl_wr0) |=> $stable(cnt0));

    // R6: a terminal count always lands in raw status
    p_fire_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire[0] |=> raw_q[0]);

    p_fire1_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire[1] |=> raw_q[1]);

    // R7: an acknowledged bit with no competing terminal count clears
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && wdata_lo[0] && !fire[0]) |=> !raw_q[0]);

    // R8: nothing reaches the line while every bit is masked off
    p_mask_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

endmodule

bind tmr_pair tmr_pair_chk #(
    .CNT_W   (CNT_W),
    .NUM_TMR (NUM_TMR),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .raw_q    (irq_raw),
    .mask_q   (irq_mask),
    .fire     (chan_fire),
    .op0      (chan_op[0]),
    .cnt0     (chan_cnt[0]),
    .ctrl0    ({chan_src[0], chan_op[0]}),
    .ctrl_wr0 (ctrl_wr[0]),
    .ack_wr   (ack_wr),
    .wdata_lo (req_wdata[1:0]),
    .tick_en  (tick_en)
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  tick_en = '0;
    logic        time_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_data;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit irq_watch = 1'b0;
    bit tick_rand = 1'b0;
    logic [3:0] tick_fixed = '0;

    // behavioural model
    logic [31:0] m_cnt [2];
    logic [31:0] m_div [2];
    logic [1:0]  m_op  [2];
    logic [2:0]  m_src [2];
    logic [1:0]  m_raw, m_mask;
    logic [31:0] m_time;

    tmr_pair u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .time_tick (time_tick),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rsp_data  (rsp_data),
        .irq_o     (irq_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a, input logic [3:0] be);
        logic [31:0] v;
        v = '0;
        if (be == 4'hF && a[1:0] == 2'b00) begin
            case (a)
                8'h00: v = m_div[0];
                8'h04: v = m_cnt[0];
                8'h08: v = {27'd0, m_src[0], m_op[0]};
                8'h10: v = m_div[1];
                8'h14: v = m_cnt[1];
                8'h18: v = {27'd0, m_src[1], m_op[1]};
                8'h38: v = m_time;
                8'h48: v = {30'd0, m_mask};
                8'h50: v = {30'd0, m_raw};
                8'h54: v = {30'd0, m_raw & m_mask};
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin
        logic       acc;
        logic [1:0] fire;
        logic [1:0] ack;
        logic       tk;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = '0; m_div[i] = '0; m_op[i] = '0; m_src[i] = '0;
            end
            m_raw = '0; m_mask = '0; m_time = '0;
        end else begin
            acc  = req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00;
            fire = '0;
            for (int i = 0; i < 2; i++) begin
                tk = (m_src[i] >= 3'd4) ? tick_en[m_src[i] - 3'd4] : 1'b0;
                if (acc && req_write && req_addr == 8'(i * 16 + 8) && req_wdata[1:0] != 2'd3) begin
                    m_op[i]  = req_wdata[1:0];
                    m_src[i] = req_wdata[4:2];
                    if (req_wdata[1:0] == 2'd0) m_cnt[i] = m_div[i];
                end else if (m_op[i] == 2'd2 && tk) begin
                    if (m_cnt[i] <= 32'd1) begin
                        m_cnt[i] = m_div[i];
                        fire[i] = 1'b1;
                    end else begin
                        m_cnt[i] = m_cnt[i] - 32'd1;
                    end
                end
                if (acc && req_write && req_addr == 8'(i * 16)) m_div[i] = req_wdata;
            end
            ack = (acc && req_write && req_addr == 8'h4C) ? req_wdata[1:0] : 2'b00;
            m_raw = (m_raw & ~ack) | fire;
            if (acc && req_write && req_addr == 8'h48) m_mask = req_wdata[1:0];
            if (time_tick) m_time = m_time + 32'd1;
        end
    end

    always @(negedge clk) begin
        tick_en <= tick_rand ? 4'($urandom) : tick_fixed;
        if (irq_watch) chk({31'd0, irq_o}, {31'd0, |(m_raw & m_mask)}, "R8 irq line");
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [3:0] be = 4'hF,
                      input bit use_lit = 1'b0, input logic [31:0] lit = '0);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        exp = use_lit ? lit : m_read(a, be);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_data, exp, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] addrs [12];
        void'($urandom(32'h5EED1234));
        addrs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h38, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h24};

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything starts at zero
        for (int k = 0; k < 11; k++) rd(addrs[k], "R1 reset value", 4'hF, 1'b1, 32'd0);
        chk({31'd0, irq_o}, 32'd0, "R1 irq low");
        irq_watch = 1'b1;

        // R2: load copies the divisor and does not count
        tick_fixed = 4'hF;
        wr(8'h00, 32'd3);
        wr(8'h08, 32'h10);
        rd(8'h04, "R2 load count", 4'hF, 1'b1, 32'd3);
        rd(8'h04, "R2 load stays", 4'hF, 1'b1, 32'd3);

        // R3: illegal code ignored
        wr(8'h08, 32'h13);
        rd(8'h08, "R3 ctrl unchanged", 4'hF, 1'b1, 32'h10);
        rd(8'h04, "R3 count unchanged", 4'hF, 1'b1, 32'd3);

        // R4: hold freezes
        wr(8'h08, 32'h11);
        rd(8'h04, "R4 held count", 4'hF, 1'b1, 32'd3);

        // R5: run, source code 4 uses tick bit 0
        wr(8'h00, 32'd40);
        wr(8'h08, 32'h10);
        tick_fixed = 4'b0001;
        wr(8'h08, 32'h12);
        rd(8'h04, "R5 running count");
        rd(8'h04, "R5 running count again");
        tick_fixed = 4'b1110;
        rd(8'h04, "R5 other ticks ignored");
        wr(8'h08, 32'h06);
        tick_fixed = 4'hF;
        rd(8'h04, "R5 source code 1 never ticks");
        rd(8'h04, "R5 source code 1 still");

        // R6: timer 1 on source 7 hits terminal count
        wr(8'h10, 32'd2);
        wr(8'h18, 32'h1C);
        tick_fixed = 4'b1000;
        wr(8'h18, 32'h1E);
        repeat (6) @(negedge clk);
        chk({30'd0, m_raw}, 32'd2, "R6 model raw bit1");
        rd(8'h50, "R6 raw status");
        rd(8'h14, "R12 timer1 count");

        // R8: mask enables the line
        wr(8'h48, 32'h2);
        chk({31'd0, irq_o}, 32'd1, "R8 irq after mask");
        rd(8'h54, "R8 masked status");

        // R7: acknowledge
        wr(8'h18, 32'h1D);
        wr(8'h4C, 32'h2);
        rd(8'h50, "R7 raw after ack", 4'hF, 1'b1, 32'd0);
        chk({31'd0, irq_o}, 32'd0, "R7 irq after ack");
        rd(8'h4C, "R7 ack reads zero", 4'hF, 1'b1, 32'd0);

        // R9: time counter
        time_tick = 1'b1;
        repeat (7) @(negedge clk);
        time_tick = 1'b0;
        rd(8'h38, "R9 time value");

        // R10: partial and misaligned accesses
        wr(8'h48, 32'h3, 4'b0111);
        rd(8'h48, "R10 partial write ignored", 4'hF, 1'b1, 32'h2);
        wr(8'h49, 32'h3);
        rd(8'h48, "R10 misaligned write ignored", 4'hF, 1'b1, 32'h2);
        rd(8'h48, "R10 partial read zero", 4'b1100, 1'b1, 32'd0);

        // R11: holes in the map
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, "R11 hole reads zero", 4'hF, 1'b1, 32'd0);
        rd(8'h3C, "R11 hole reads zero", 4'hF, 1'b1, 32'd0);
        rd(8'h08, "R12 ctrl layout", 4'hF, 1'b1, 32'h06);

        // random phase
        tick_rand = 1'b1;
        for (int n = 0; n < 1500; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic [3:0]  be;
            int          sel;
            a   = addrs[$urandom_range(0, 11)];
            sel = $urandom_range(0, 9);
            be  = (sel == 0) ? 4'($urandom) : 4'hF;
            time_tick = 1'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                d = (a[3:0] == 4'h0) ? 32'($urandom_range(0, 12)) : 32'($urandom);
                if (a == 8'h08 || a == 8'h18) d = 32'($urandom_range(0, 31));
                wr(a, d, be);
            end else begin
                rd(a, "R12 random read", be);
            end
        end

        irq_watch = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule